// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading up to two entries of a translation table that lives in ordinary memory. A requester hands it one virtual address together with two attributes: whether the access is a write, and whether it comes from user mode. The walker fetches the top-level entry at the address given by the root frame input. It then either stops there, for a 4 MB large page, or fetches a second-level entry. Each fetch is a 32-bit read over a request/response memory port.

After the walk, the block applies the present and permission rules. On success it writes the accessed flag back to every entry it used, and for a write it also sets the dirty flag on the final entry. It then returns one response: a physical address, or a three-bit fault code. It accepts a new request only after the previous one has been answered.

Top module: `pgwalk_top`

## Requirements
- R1: The top-level entry is read at {root_frame, VA[31:22], 2'b00}. For a 4 KB mapping, the second-level entry is read at {top entry[31:12], VA[21:12], 2'b00}, and the physical address is {second-level entry[31:12], VA[11:0]}.
- R2: Entry bit 0 marks the entry present. Bits 9 to 11 of an entry never change the physical address or the outcome. A missing entry at either level produces a fault with code bit 0 clear.
- R3: When large_en is 1 and bit 7 of a present top-level entry is set, no second-level read takes place, and the physical address is {top entry[31:22], VA[21:0]}.
- R4: When large_en is 0, bit 7 is ignored and the walk always continues to the second level.
- R5: A user-mode access faults with code bit 0 set in two cases: either level has bit 2 (user allowed) clear, or the access is a write and either level has bit 1 (writable) clear.
- R6: A supervisor-mode access never takes a protection fault. Bit 1 and bit 2 are ignored for it, so a supervisor write to a read-only page succeeds.
- R7: In a fault code, bit 1 equals the write attribute of the request and bit 2 equals its user attribute.
- R8: After a successful walk, each entry used whose bit 5 (accessed) is clear is written back with bit 5 set. A write sets bit 6 (dirty) on the final-level entry only. A faulting walk writes nothing to memory.
- R9: req_ready is high only while the walker is idle. rsp_valid is a single-cycle pulse, and req_ready is low while rsp_valid is high.
- R10: A memory request that has not yet been accepted keeps its valid, address, write enable and write data unchanged until mem_req_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_frame | input | 20 | Frame number of the top-level table |
| large_en | input | 1 | Enables 4 MB mappings at the top level |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| req_user | input | 1 | Request is made in user mode |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | 1 = translation succeeded, 0 = fault |
| rsp_paddr | output | 32 | Physical address when rsp_ok is 1 |
| rsp_fault | output | 3 | Fault code: bit0 protection, bit1 write, bit2 user |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Memory request is a write-back |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated entry for a write-back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Entry read from memory |

## Verification
The checker relies on three properties of the environment. Memory returns exactly one read response for each accepted read and none for writes. req_write and req_user are captured on the request handshake and matched against the fault code. large_en and root_frame stay constant during a walk. The bench memory model grants requests on an irregular ready pattern and answers each accepted read one cycle later. The bench changes large_en only between walks, and it presents each request only after the previous response has arrived.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  // entry flag positions (decoded by the walker itself)
  localparam int unsigned B_PRES  = 0;
  localparam int unsigned B_WRITE = 1;
  localparam int unsigned B_USER  = 2;
  localparam int unsigned B_ACC   = 5;
  localparam int unsigned B_DIRTY = 6;
  localparam int unsigned B_LARGE = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RQ,
    ST_DIR_WT,
    ST_TBL_RQ,
    ST_TBL_WT,
    ST_UPD_DIR,
    ST_UPD_TBL,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int unsigned IDX_W = 10
) (
  input  logic [3*IDX_W+1:0]   vaddr,
  input  logic [2*IDX_W-1:0]   root_frame,
  input  logic [3*IDX_W+1:0]   dir_ent,
  input  logic [3*IDX_W+1:0]   tbl_ent,
  output logic [3*IDX_W+1:0]   dir_addr,
  output logic [3*IDX_W+1:0]   tbl_addr,
  output logic [3*IDX_W+1:0]   pa_small,
  output logic [3*IDX_W+1:0]   pa_large
);
  localparam int unsigned OFF_W = IDX_W + 2;
  localparam int unsigned VA_W  = 3 * IDX_W + 2;
  localparam int unsigned LO_W  = OFF_W + IDX_W;

  assign dir_addr = {root_frame, vaddr[VA_W-1:LO_W], 2'b00};
  assign tbl_addr = {dir_ent[VA_W-1:OFF_W], vaddr[LO_W-1:OFF_W], 2'b00};
  assign pa_small = {tbl_ent[VA_W-1:OFF_W], vaddr[OFF_W-1:0]};
  assign pa_large = {dir_ent[VA_W-1:LO_W], vaddr[LO_W-1:0]};
endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm (
  input  logic rw_eff,
  input  logic us_eff,
  input  logic is_write,
  input  logic is_user,
  output logic viol
);
  // supervisor accesses skip both checks
  assign viol = is_user & (~us_eff | (is_write & ~rw_eff));
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2*IDX_W-1:0]   root_frame,
  input  logic                 large_en,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [3*IDX_W+1:0]   req_vaddr,
  input  logic                 req_write,
  input  logic                 req_user,
  output logic                 rsp_valid,
  output logic                 rsp_ok,
  output logic [3*IDX_W+1:0]   rsp_paddr,
  output logic [2:0]           rsp_fault,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_we,
  output logic [3*IDX_W+1:0]   mem_req_addr,
  output logic [3*IDX_W+1:0]   mem_req_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [3*IDX_W+1:0]   mem_rsp_rdata
);
  localparam int unsigned VA_W = 3 * IDX_W + 2;
  localparam logic [VA_W-1:0] M_ACC   = VA_W'(1) << B_ACC;
  localparam logic [VA_W-1:0] M_DIRTY = VA_W'(1) << B_DIRTY;

  walk_st_e          state;
  logic [VA_W-1:0]   va_q, pde_q, pte_q, paddr_q;
  logic              wr_q, us_q, large_q, upd_tbl_q, ok_q;
  logic [2:0]        fault_q;

  logic [VA_W-1:0]   pde_cur, dir_addr, tbl_addr, pa_small, pa_large;
  logic              perm_rw, perm_us, viol;
  logic              rd_pres, rd_acc, rd_dirty, rd_large, tbl_needs_wb;

  assign pde_cur = (state == ST_DIR_WT) ? mem_rsp_rdata : pde_q;

  pgwalk_addr #(.IDX_W(IDX_W)) u_addr (
    .vaddr      (va_q),
    .root_frame (root_frame),
    .dir_ent    (pde_cur),
    .tbl_ent    (mem_rsp_rdata),
    .dir_addr   (dir_addr),
    .tbl_addr   (tbl_addr),
    .pa_small   (pa_small),
    .pa_large   (pa_large)
  );

  // second-level check combines both levels
  assign perm_rw = mem_rsp_rdata[B_WRITE] & ((state != ST_TBL_WT) | pde_q[B_WRITE]);
  assign perm_us = mem_rsp_rdata[B_USER]  & ((state != ST_TBL_WT) | pde_q[B_USER]);

  pgwalk_perm u_perm (
    .rw_eff   (perm_rw),
    .us_eff   (perm_us),
    .is_write (wr_q),
    .is_user  (us_q),
    .viol     (viol)
  );

  assign rd_pres      = mem_rsp_rdata[B_PRES];
  assign rd_acc       = mem_rsp_rdata[B_ACC];
  assign rd_dirty     = mem_rsp_rdata[B_DIRTY];
  assign rd_large     = mem_rsp_rdata[B_LARGE];
  assign tbl_needs_wb = ~rd_acc | (wr_q & ~rd_dirty);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      va_q      <= '0;
      pde_q     <= '0;
      pte_q     <= '0;
      paddr_q   <= '0;
      wr_q      <= 1'b0;
      us_q      <= 1'b0;
      large_q   <= 1'b0;
      upd_tbl_q <= 1'b0;
      ok_q      <= 1'b0;
      fault_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          wr_q  <= req_write;
          us_q  <= req_user;
          state <= ST_DIR_RQ;
        end
        ST_DIR_RQ: if (mem_req_ready) state <= ST_DIR_WT;
        ST_DIR_WT: if (mem_rsp_valid) begin
          pde_q     <= mem_rsp_rdata;
          upd_tbl_q <= 1'b0;
          if (!rd_pres) begin
            ok_q    <= 1'b0;
            fault_q <= {us_q, wr_q, 1'b0};
            state   <= ST_DONE;
          end else if (large_en && rd_large) begin
            large_q <= 1'b1;
            if (viol) begin
              ok_q    <= 1'b0;
              fault_q <= {us_q, wr_q, 1'b1};
              state   <= ST_DONE;
            end else begin
              ok_q    <= 1'b1;
              paddr_q <= pa_large;
              state   <= tbl_needs_wb ? ST_UPD_DIR : ST_DONE;
            end
          end else begin
            large_q <= 1'b0;
            state   <= ST_TBL_RQ;
          end
        end
        ST_TBL_RQ: if (mem_req_ready) state <= ST_TBL_WT;
        ST_TBL_WT: if (mem_rsp_valid) begin
          pte_q <= mem_rsp_rdata;
          if (!rd_pres) begin
            ok_q    <= 1'b0;
            fault_q <= {us_q, wr_q, 1'b0};
            state   <= ST_DONE;
          end else if (viol) begin
            ok_q    <= 1'b0;
            fault_q <= {us_q, wr_q, 1'b1};
            state   <= ST_DONE;
          end else begin
            ok_q      <= 1'b1;
            paddr_q   <= pa_small;
            upd_tbl_q <= tbl_needs_wb;
            if (!pde_q[B_ACC])     state <= ST_UPD_DIR;
            else if (tbl_needs_wb) state <= ST_UPD_TBL;
            else                   state <= ST_DONE;
          end
        end
        ST_UPD_DIR: if (mem_req_ready)
          state <= (!large_q && upd_tbl_q) ? ST_UPD_TBL : ST_DONE;
        ST_UPD_TBL: if (mem_req_ready) state <= ST_DONE;
        ST_DONE:    state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = (state == ST_DONE);
  assign rsp_ok        = ok_q;
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;

  assign mem_req_valid = (state == ST_DIR_RQ) || (state == ST_TBL_RQ) ||
                         (state == ST_UPD_DIR) || (state == ST_UPD_TBL);
  assign mem_req_we    = (state == ST_UPD_DIR) || (state == ST_UPD_TBL);
  assign mem_req_addr  = ((state == ST_TBL_RQ) || (state == ST_UPD_TBL)) ? tbl_addr : dir_addr;

  always_comb begin
    mem_req_wdata = '0;
    if (state == ST_UPD_DIR)
      mem_req_wdata = pde_q | M_ACC | ((large_q && wr_q) ? M_DIRTY : '0);
    else if (state == ST_UPD_TBL)
      mem_req_wdata = pte_q | M_ACC | (wr_q ? M_DIRTY : '0);
  end
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int unsigned IDX_W = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic                 req_user,
  input logic                 rsp_valid,
  input logic                 rsp_ok,
  input logic [2:0]           rsp_fault,
  input logic                 mem_req_valid,
  input logic                 mem_req_ready,
  input logic                 mem_req_we,
  input logic [3*IDX_W+1:0]   mem_req_addr,
  input logic [3*IDX_W+1:0]   mem_req_wdata
);
  logic wr_seen, us_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_seen <= 1'b0;
      us_seen <= 1'b0;
    end else if (req_valid && req_ready) begin
      wr_seen <= req_write;
      us_seen <= req_user;
    end
  end

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_we) && $stable(mem_req_wdata));

  a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r9_busy_resp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  a_r7_fault_attr: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ok |-> rsp_fault[1] == wr_seen && rsp_fault[2] == us_seen);

  a_r6_sup_no_prot: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !us_seen |-> rsp_ok || !rsp_fault[0]);

  a_r8_wb_sets_acc: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_we |-> mem_req_wdata[5] && mem_req_wdata[0]);
endmodule

bind pgwalk_top pgwalk_chk #(.IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .req_user      (req_user),
  .rsp_valid     (rsp_valid),
  .rsp_ok        (rsp_ok),
  .rsp_fault     (rsp_fault),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata)
);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] root_frame = 20'h00100;
  logic        large_en = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_ok;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_fault;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pgwalk_top u_dut (
    .clk(clk), .rst(rst), .root_frame(root_frame), .large_en(large_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  // memory model: irregular grant, read data one cycle after acceptance
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[mem_req_addr] = mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= rd(mem_req_addr);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic        got_ok;
  logic [31:0] got_pa;
  logic [2:0]  got_fault;

  task automatic walk(input logic [31:0] va, input logic wr, input logic us);
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_user = us; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 busy after accept", {31'b0, req_ready}, 32'h0);
    while (!rsp_valid) @(negedge clk);
    got_ok = rsp_ok; got_pa = rsp_paddr; got_fault = rsp_fault;
    check("R9 not ready during response", {31'b0, req_ready}, 32'h0);
    @(negedge clk);
    check("R9 response is one pulse", {31'b0, rsp_valid}, 32'h0);
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        us;
    logic        ok;
    logic [31:0] pa;
    logic [2:0]  fault;
  } vec_t;

  // fault code: bit0 protection, bit1 write, bit2 user
  localparam vec_t VECS [12] = '{
    '{32'h00400123, 1'b0, 1'b1, 1'b1, 32'h0000A123, 3'd0},  // R1 R2 4K user read
    '{32'h00401456, 1'b1, 1'b1, 1'b0, 32'h0,        3'd7},  // R5 user write RO
    '{32'h00401456, 1'b1, 1'b0, 1'b1, 32'h0000B456, 3'd0},  // R6 sup write RO
    '{32'h00402000, 1'b0, 1'b1, 1'b0, 32'h0,        3'd4},  // R2 second level absent
    '{32'h00800010, 1'b0, 1'b0, 1'b0, 32'h0,        3'd0},  // R2 top level absent
    '{32'h00C12345, 1'b1, 1'b1, 1'b1, 32'h0C012345, 3'd0},  // R3 large write
    '{32'h00403ABC, 1'b0, 1'b1, 1'b0, 32'h0,        3'd5},  // R5 leaf sup-only
    '{32'h01000020, 1'b0, 1'b1, 1'b0, 32'h0,        3'd5},  // R5 top sup-only
    '{32'h01000020, 1'b1, 1'b0, 1'b1, 32'h0000E020, 3'd0},  // R6 sup ignores top RO
    '{32'h01400777, 1'b1, 1'b1, 1'b0, 32'h0,        3'd7},  // R5 R7 large RO write
    '{32'h01400777, 1'b0, 1'b1, 1'b1, 32'h10000777, 3'd0},  // R3 large read
    '{32'h00400FFF, 1'b1, 1'b1, 1'b1, 32'h0000AFFF, 3'd0}   // R1 R8 write sets dirty
  };

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=finish", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mem[32'h00100004] = 32'h00200007;   // top 1 -> table at 0x200000
    mem[32'h0010000C] = 32'h0C000087;   // top 3 large, rw user
    mem[32'h00100010] = 32'h00300001;   // top 4 sup-only, RO
    mem[32'h00100014] = 32'h10000085;   // top 5 large, RO user
    mem[32'h00200000] = 32'h0000AE07;   // ignored bits 9..11 set
    mem[32'h00200004] = 32'h0000B005;
    mem[32'h0020000C] = 32'h0000D003;
    mem[32'h00300000] = 32'h0000E007;
    mem[32'h0C000048] = 32'h00055007;   // reached only with large pages off

    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R9 reset ready", {31'b0, req_ready}, 32'h1);
    check("R9 reset no response", {31'b0, rsp_valid}, 32'h0);
    check("R10 reset no mem request", {31'b0, mem_req_valid}, 32'h0);
    rst = 1'b0;

    foreach (VECS[i]) begin
      walk(VECS[i].va, VECS[i].wr, VECS[i].us);
      check($sformatf("R1 R3 R5 R6 ok vec%0d", i), {31'b0, got_ok}, {31'b0, VECS[i].ok});
      if (VECS[i].ok) check($sformatf("R1 R3 paddr vec%0d", i), got_pa, VECS[i].pa);
      else check($sformatf("R2 R5 R7 fault vec%0d", i), {29'b0, got_fault}, {29'b0, VECS[i].fault});
    end

    // R8 write-back results
    check("R8 top1 accessed",         rd(32'h00100004), 32'h00200027);
    check("R8 leaf dirty after write", rd(32'h00200000), 32'h0000AE67);
    check("R8 R6 sup write dirty",     rd(32'h00200004), 32'h0000B065);
    check("R8 absent leaf untouched",  rd(32'h00200008), 32'h0);
    check("R8 faulted leaf untouched", rd(32'h0020000C), 32'h0000D003);
    check("R8 large dirty",            rd(32'h0010000C), 32'h0C0000E7);
    check("R8 top4 accessed no dirty", rd(32'h00100010), 32'h00300021);
    check("R8 leaf under top4",        rd(32'h00300000), 32'h0000E067);
    check("R8 large read accessed",    rd(32'h00100014), 32'h100000A5);
    check("R8 absent top untouched",   rd(32'h00100008), 32'h0);

    // R4: large pages disabled, bit 7 used as a table pointer
    large_en = 1'b0;
    walk(32'h00C12345, 1'b0, 1'b1);
    check("R4 ok with large off", {31'b0, got_ok}, 32'h1);
    check("R4 paddr via second level", got_pa, 32'h00055345);
    check("R4 R8 leaf accessed", rd(32'h0C000048), 32'h00055027);
    walk(32'h00C00010, 1'b0, 1'b0);
    check("R4 R2 absent leaf", {31'b0, got_ok}, 32'h0);
    check("R4 R7 fault code", {29'b0, got_fault}, 32'h0);
    check("R4 R8 top3 unchanged", rd(32'h0010000C), 32'h0C0000E7);

    // R9: reset in the middle of a walk returns to idle
    @(negedge clk);
    req_vaddr = 32'h00400000; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 ready after mid-walk reset", {31'b0, req_ready}, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule